// File: doc/BRIEF.md
# Serial audio bit clock and frame sync generator

This block produces the timing for a serial audio port whose clocks are driven from this side of the link. It divides a master clock down to a bit clock in three stacked stages: an optional divide-by-8 prescale, an optional divide-by-2 and a programmable modulus. It then counts bit clock periods into words and frames. From these counts it drives a frame sync, and it reports the current bit and word position so that shift logic next to it can follow the frame.

The programmed setup covers the divide modulus, the two prescale selects, a word size code and a words-per-frame code. A stereo-pair mode replaces that geometry with two 32-bit words per frame and turns the frame sync into a word-select signal. The setup is sampled only while the block is disabled or at a frame boundary, so the bit clock never has a truncated half period. After enable, and after every boundary, it starts at the first bit of the first word.

Top module: `audio_clk_gen`

## Requirements
- R1: With both prescale selects low, the bit clock period is 2×(PM+1) master clocks, with high and low halves of PM+1 master clocks each. After enable, the first rising edge follows the (PM+1)-th enabled clock edge.
- R2: psr_i=1 multiplies every half period by 8 and div2_i=1 multiplies it by 2. With both set the factor is 16.
- R3: A word holds 2×(WL+1) bits. bit_idx_o reads 0 for the first bit and steps by one at each bit clock rising edge, wrapping after 2×WL+1.
- R4: A frame holds DC+1 words. word_idx_o steps when bit_idx_o wraps and returns to 0 after DC.
- R5: Outside stereo-pair mode, fs_o is 1 for exactly the bit clock period that starts at the rising edge opening bit 0 of word 0, and 0 at all other times.
- R6: With i2s_i=1, words are 32 bits and a frame is 2 words, whatever WL and DC hold. fs_o equals bit 0 of word_idx_o: 0 during word 0 and 1 during word 1.
- R7: A clock edge that samples en_i=0 leaves bclk_o, fs_o, bit_idx_o and word_idx_o at 0. On the next enable, counting restarts from bit 0 of word 0.
- R8: While rst_ni is low, all outputs are 0 regardless of the other inputs.
- R9: Setup changes made while enabled take effect at the rising edge that opens the next frame. The halves before that edge keep the old timing. The high half that starts at that edge, and everything after it, uses the new timing.
- R10: bit_idx_o, word_idx_o and fs_o change only together with a bit clock rising edge, or on disable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | master clock |
| rst_ni | input | 1 | asynchronous reset, active low |
| en_i | input | 1 | run enable |
| pm_i | input | 8 | divide modulus, half period = PM+1 prescaled ticks |
| psr_i | input | 1 | divide-by-8 prescale select |
| div2_i | input | 1 | divide-by-2 prescale select |
| wl_i | input | 4 | word size code, 2×(WL+1) bits |
| dc_i | input | 5 | frame size code, DC+1 words |
| i2s_i | input | 1 | stereo-pair mode select |
| bclk_o | output | 1 | bit clock |
| fs_o | output | 1 | frame sync or word select |
| bit_idx_o | output | 5 | bit position in the current word |
| word_idx_o | output | 5 | word position in the current frame |

## Verification
The divider is swept over every modulus from 0 to 7 with both prescale selects low, and over small moduli with each other select combination. This separates a wrong modulus from a missing or doubled prescale stage. The geometry is swept over all word and frame codes from 0 to 3 at two divide settings. This exposes word and frame wrap errors and a frame sync that is misplaced or held too long. Stereo-pair mode runs with deliberately odd WL and DC values to show that they are overridden. A mid-frame change of modulus and word size, checked cycle by cycle against a hand-derived sequence, shows whether the change lands at the frame boundary or too early.

// File: rtl/acg_pkg.sv
`timescale 1ns/1ps
package acg_pkg;
  localparam int PM_W      = 8;
  localparam int WL_W      = 4;
  localparam int DC_W      = 5;
  localparam int IDX_W     = WL_W + 1;
  localparam int I2S_BITS  = 32;
  localparam int I2S_WORDS = 2;

  typedef struct packed {
    logic [PM_W-1:0] pm;
    logic            psr;
    logic            div2;
    logic [WL_W-1:0] wl;
    logic [DC_W-1:0] dc;
    logic            i2s;
  } acg_cfg_t;
endpackage

// File: rtl/acg_prescale.sv
`timescale 1ns/1ps
module acg_prescale #(
  parameter int PRE_DIV = 8
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  input  logic psr_i,
  input  logic div2_i,
  output logic tick_o
);
  localparam int CW = $clog2(PRE_DIV);

  logic [CW-1:0] pre_q;
  logic          half_q;
  logic          tick_pre;

  assign tick_pre = psr_i ? (pre_q == CW'(PRE_DIV - 1)) : 1'b1;
  assign tick_o   = run_i & (div2_i ? (half_q & tick_pre) : tick_pre);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pre_q  <= '0;
      half_q <= 1'b0;
    end else if (!run_i) begin
      pre_q  <= '0;
      half_q <= 1'b0;
    end else begin
      pre_q <= tick_pre ? '0 : pre_q + 1'b1;
      if (!div2_i)       half_q <= 1'b0;
      else if (tick_pre) half_q <= ~half_q;
    end
  end
endmodule

// File: rtl/acg_bclk_div.sv
`timescale 1ns/1ps
module acg_bclk_div
  import acg_pkg::*;
(
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            run_i,
  input  logic            tick_i,
  input  logic [PM_W-1:0] pm_i,
  output logic            bclk_o,
  output logic            rise_o
);
  logic [PM_W-1:0] hc_q;
  logic            bclk_q;
  logic            flip;

  assign flip   = tick_i && (hc_q == pm_i);
  assign rise_o = flip & ~bclk_q;
  assign bclk_o = bclk_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hc_q   <= '0;
      bclk_q <= 1'b0;
    end else if (!run_i) begin
      hc_q   <= '0;
      bclk_q <= 1'b0;
    end else if (tick_i) begin
      if (flip) begin
        hc_q   <= '0;
        bclk_q <= ~bclk_q;
      end else begin
        hc_q <= hc_q + 1'b1;
      end
    end
  end
endmodule

// File: rtl/acg_frame_ctr.sv
`timescale 1ns/1ps
module acg_frame_ctr
  import acg_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic             step_i,
  input  logic [IDX_W-1:0] bit_last_i,
  input  logic [DC_W-1:0]  word_last_i,
  input  logic             i2s_i,
  input  logic             i2s_next_i,
  output logic [IDX_W-1:0] bit_o,
  output logic [DC_W-1:0]  word_o,
  output logic             fs_o,
  output logic             wrap_o
);
  logic             started_q;
  logic [IDX_W-1:0] bit_q, nb;
  logic [DC_W-1:0]  word_q, nw;
  logic             fs_q, fs_n, mode, bit_end, word_end;

  assign bit_end  = (bit_q == bit_last_i);
  assign word_end = (word_q == word_last_i);
  assign wrap_o   = step_i & started_q & bit_end & word_end;

  always_comb begin
    nb = bit_q + 1'b1;
    nw = word_q;
    if (!started_q) begin
      nb = '0;
      nw = '0;
    end else if (bit_end) begin
      nb = '0;
      nw = word_end ? '0 : word_q + 1'b1;
    end
    // first word of a new frame obeys the mode loaded at that boundary
    mode = wrap_o ? i2s_next_i : i2s_i;
    fs_n = mode ? nw[0] : (nb == '0 && nw == '0);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      started_q <= 1'b0;
      bit_q     <= '0;
      word_q    <= '0;
      fs_q      <= 1'b0;
    end else if (!run_i) begin
      started_q <= 1'b0;
      bit_q     <= '0;
      word_q    <= '0;
      fs_q      <= 1'b0;
    end else if (step_i) begin
      started_q <= 1'b1;
      bit_q     <= nb;
      word_q    <= nw;
      fs_q      <= fs_n;
    end
  end

  assign bit_o  = bit_q;
  assign word_o = word_q;
  assign fs_o   = fs_q;
endmodule

// File: rtl/audio_clk_gen.sv
`timescale 1ns/1ps
module audio_clk_gen
  import acg_pkg::*;
#(
  parameter int PRE_DIV = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic [PM_W-1:0]  pm_i,
  input  logic             psr_i,
  input  logic             div2_i,
  input  logic [WL_W-1:0]  wl_i,
  input  logic [DC_W-1:0]  dc_i,
  input  logic             i2s_i,
  output logic             bclk_o,
  output logic             fs_o,
  output logic [IDX_W-1:0] bit_idx_o,
  output logic [DC_W-1:0]  word_idx_o
);
  acg_cfg_t         cfg_in, cfg_q;
  logic             tick, rise, wrap;
  logic             act_i2s;
  logic [IDX_W-1:0] act_bit_last;
  logic [DC_W-1:0]  act_word_last;

  assign cfg_in = '{pm: pm_i, psr: psr_i, div2: div2_i, wl: wl_i, dc: dc_i, i2s: i2s_i};

  // shadow setup: open while idle, otherwise only at frame wrap
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)             cfg_q <= '0;
    else if (!en_i || wrap)  cfg_q <= cfg_in;
  end

  assign act_i2s       = cfg_q.i2s;
  assign act_bit_last  = act_i2s ? IDX_W'(I2S_BITS - 1) : {cfg_q.wl, 1'b1};
  assign act_word_last = act_i2s ? DC_W'(I2S_WORDS - 1) : cfg_q.dc;

  acg_prescale #(.PRE_DIV(PRE_DIV)) u_pre (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .run_i  (en_i),
    .psr_i  (cfg_q.psr),
    .div2_i (cfg_q.div2),
    .tick_o (tick)
  );

  acg_bclk_div u_div (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .run_i  (en_i),
    .tick_i (tick),
    .pm_i   (cfg_q.pm),
    .bclk_o (bclk_o),
    .rise_o (rise)
  );

  acg_frame_ctr u_frm (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .run_i       (en_i),
    .step_i      (rise),
    .bit_last_i  (act_bit_last),
    .word_last_i (act_word_last),
    .i2s_i       (act_i2s),
    .i2s_next_i  (i2s_i),
    .bit_o       (bit_idx_o),
    .word_o      (word_idx_o),
    .fs_o        (fs_o),
    .wrap_o      (wrap)
  );
endmodule

// File: rtl/acg_chk.sv
`timescale 1ns/1ps
module acg_chk
  import acg_pkg::*;
(
  input logic             clk_i,
  input logic             rst_ni,
  input logic             en_i,
  input logic             bclk_o,
  input logic             fs_o,
  input logic [IDX_W-1:0] bit_idx_o,
  input logic [DC_W-1:0]  word_idx_o,
  input logic             act_i2s,
  input logic [IDX_W-1:0] act_bit_last,
  input logic [DC_W-1:0]  act_word_last
);
  // R7
  idle_after_disable_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> (!bclk_o && !fs_o && bit_idx_o == '0 && word_idx_o == '0));

  // R10
  bit_on_rise_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bit_idx_o != $past(bit_idx_o)) |-> ($rose(bclk_o) || !$past(en_i)));

  // R10
  fs_on_rise_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fs_o != $past(fs_o)) |-> ($rose(bclk_o) || !$past(en_i)));

  // R5
  fs_frame_start_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fs_o && !act_i2s) |-> (bit_idx_o == '0 && word_idx_o == '0));

  // R3
  bit_in_word_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bit_idx_o <= act_bit_last);

  // R4
  word_in_frame_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    word_idx_o <= act_word_last);

  // R6
  ws_follows_word_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    act_i2s |-> (fs_o == word_idx_o[0]));
endmodule

bind audio_clk_gen acg_chk u_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .en_i          (en_i),
  .bclk_o        (bclk_o),
  .fs_o          (fs_o),
  .bit_idx_o     (bit_idx_o),
  .word_idx_o    (word_idx_o),
  .act_i2s       (act_i2s),
  .act_bit_last  (act_bit_last),
  .act_word_last (act_word_last)
);

// File: tb/audio_clk_gen_test.sv
`timescale 1ns/1ps
module audio_clk_gen_test;
  import acg_pkg::*;

  logic             clk = 1'b0;
  logic             rst_ni = 1'b0;
  logic             en_i = 1'b0;
  logic [PM_W-1:0]  pm_i = '0;
  logic             psr_i = 1'b0;
  logic             div2_i = 1'b0;
  logic [WL_W-1:0]  wl_i = '0;
  logic [DC_W-1:0]  dc_i = '0;
  logic             i2s_i = 1'b0;
  logic             bclk_o, fs_o;
  logic [IDX_W-1:0] bit_idx_o;
  logic [DC_W-1:0]  word_idx_o;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  audio_clk_gen uut (
    .clk_i(clk), .rst_ni(rst_ni), .en_i(en_i), .pm_i(pm_i), .psr_i(psr_i),
    .div2_i(div2_i), .wl_i(wl_i), .dc_i(dc_i), .i2s_i(i2s_i),
    .bclk_o(bclk_o), .fs_o(fs_o), .bit_idx_o(bit_idx_o), .word_idx_o(word_idx_o)
  );

  task automatic check(input string tag, input int eb, input int ef, input int ebit, input int ew);
    checks++;
    if (int'(bclk_o) != eb || int'(fs_o) != ef || int'(bit_idx_o) != ebit || int'(word_idx_o) != ew) begin
      errors++;
      $display("FAIL %s t=%0t: got bclk=%0d fs=%0d bit=%0d word=%0d, expected bclk=%0d fs=%0d bit=%0d word=%0d",
               tag, $time, bclk_o, fs_o, bit_idx_o, word_idx_o, eb, ef, ebit, ew);
    end
  endtask

  // enable with a fixed setup and compare every cycle to the arithmetic model
  task automatic run_cfg(input string tag, input int pm, input int psr, input int div2,
                         input int wl, input int dc, input int i2s, input int frames);
    int h, bpw, nwd, cycles;
    h   = (pm + 1) * (psr != 0 ? 8 : 1) * (div2 != 0 ? 2 : 1);
    bpw = (i2s != 0) ? 32 : 2 * (wl + 1);
    nwd = (i2s != 0) ? 2 : dc + 1;
    cycles = 2 * h * bpw * nwd * frames + 2;
    @(negedge clk);
    en_i = 1'b0; pm_i = PM_W'(pm); psr_i = psr[0]; div2_i = div2[0];
    wl_i = WL_W'(wl); dc_i = DC_W'(dc); i2s_i = i2s[0];
    @(posedge clk); #1;
    check("R7 idle after disable", 0, 0, 0, 0);
    @(negedge clk);
    en_i = 1'b1;
    for (int k = 0; k < cycles; k++) begin
      int n, r, p, b, w, f;
      @(posedge clk); #1;
      n = (k + 1) / h;
      r = (n + 1) / 2;
      if (r == 0) begin
        b = 0; w = 0; f = 0;
      end else begin
        p = r - 1;
        b = p % bpw;
        w = (p / bpw) % nwd;
        f = (i2s != 0) ? (w % 2) : ((b == 0 && w == 0) ? 1 : 0);
      end
      check(tag, n % 2, f, b, w);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    // R8: reset dominates even with enable high
    en_i = 1'b1; pm_i = 8'd1; wl_i = 4'd3; dc_i = 5'd1;
    repeat (4) @(posedge clk);
    #1;
    check("R8 reset", 0, 0, 0, 0);
    @(negedge clk);
    en_i = 1'b0;
    rst_ni = 1'b1;

    // R1: modulus sweep without prescale
    for (int pm = 0; pm < 8; pm++) run_cfg("R1 modulus", pm, 0, 0, 0, 1, 0, 2);

    // R2: prescale stages
    for (int pm = 0; pm < 3; pm++) begin
      run_cfg("R2 div8", pm, 1, 0, 0, 1, 0, 2);
      run_cfg("R2 div2", pm, 0, 1, 0, 1, 0, 2);
      run_cfg("R2 div16", pm, 1, 1, 0, 1, 0, 2);
    end

    // R3 R4 R5 R10: geometry sweep
    for (int wl = 0; wl < 4; wl++)
      for (int dc = 0; dc < 4; dc++) begin
        run_cfg("R3 R4 R5 R10 geometry", 0, 0, 0, wl, dc, 0, 2);
        run_cfg("R3 R4 R5 R10 geometry", 1, 0, 0, wl, dc, 0, 1);
      end

    // R6: stereo-pair mode ignores WL and DC
    run_cfg("R6 stereo", 0, 0, 0, 0, 0, 1, 2);
    run_cfg("R6 stereo", 1, 0, 0, 7, 3, 1, 2);
    run_cfg("R6 stereo", 0, 1, 0, 15, 31, 1, 1);

    // R7: restart after mid-frame disable lands on bit 0 of word 0
    run_cfg("R7 restart", 2, 0, 1, 2, 2, 0, 1);

    // R9: change PM and WL mid-frame; takes effect at next frame start
    begin
      int eb[23]   = '{0,1,1,0,0,1,1,0,0,1,1,0,0,1,1,0,0,1,0,1,0,1,0};
      int ebit[23] = '{0,0,0,0,0,1,1,1,1,2,2,2,2,3,3,3,3,0,0,1,1,0,0};
      int ef[23]   = '{0,1,1,1,1,0,0,0,0,0,0,0,0,0,0,0,0,1,1,0,0,1,1};
      @(negedge clk);
      en_i = 1'b0; pm_i = 8'd1; psr_i = 1'b0; div2_i = 1'b0;
      wl_i = 4'd1; dc_i = 5'd0; i2s_i = 1'b0;
      @(negedge clk);
      en_i = 1'b1;
      for (int k = 0; k < 23; k++) begin
        @(posedge clk); #1;
        check("R9 deferred update", eb[k], ef[k], ebit[k], 0);
        if (k == 5) begin
          pm_i = 8'd0;
          wl_i = 4'd0;
        end
      end
    end

    // R7: disable again, outputs return to idle
    @(negedge clk);
    en_i = 1'b0;
    @(posedge clk); #1;
    check("R7 idle after disable", 0, 0, 0, 0);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule